// File: doc/BRIEF.md
# Return-Address Stack with Background Row Refresh

This block keeps the return addresses of a small processor in an eight-row by 14-bit register array, and the row picked by the stack pointer is the program counter itself. No separate program-counter register exists. A call moves the pointer one step forward and writes the target into the newly selected row. The old value stays in the row below and needs no copy. A return moves the pointer one step back. An increment rewrites the selected row with its value plus one. The pointer is a three-bit shift counter that runs through a de Bruijn cycle instead of binary order. Calls and returns walk the same cycle in opposite directions, so every return finds the row its call wrote.

A narrow 8-bit bus connects the stack to the rest of the processor. One half of the selected row moves per command: the low byte, or the six remaining high bits. Because the storage models a cell array that must be rewritten at regular intervals, a second shift counter that only counts up walks the rows in the background. A refresh is a two-step sequence run by a small state machine. In SCAN the machine waits for an idle cycle and senses the row under the refresh counter into a holding copy, then moves to HOLD. In HOLD it waits for the next idle cycle, writes the copy back, reports the row and returns to SCAN with the counter advanced. If the stack writes the held row while the machine is in HOLD, the copy is dropped and the machine returns to SCAN with the counter advanced. That stack write has already renewed the row. In every other case each state holds.

Top module: `ras_top`

## Requirements
- R1: While reset is held, and right after it is released, `pc_o` is 0, `bus_o` is 0 and `rfsh_done_o` is 0. Every row resets to 0, and both counters reset to code 000.
- R2: Command code 1 (call) advances the pointer one step and writes `tgt_i` into the newly selected row, so `pc_o` equals `tgt_i` after that clock edge.
- R3: Command code 2 (return) steps the pointer back one position and writes no row, so `pc_o` shows the entry that was selected before the matching call.
- R4: Command code 3 (increment) replaces the selected row with its value plus one, modulo 2^14 (3FFF becomes 0000). The pointer does not move.
- R5: Command code 5 (read half) loads `bus_o` at the clock edge with bits 7:0 of the selected row when `half_sel_i` is 0, or with {2'b00, bits 13:8} when it is 1. `bus_o` keeps its value on every other command.
- R6: Command code 4 (load half) writes `bus_i` into bits 7:0 of the selected row when `half_sel_i` is 0, or writes `bus_i[5:0]` into bits 13:8 when it is 1. The other half of the row is kept.
- R7: The pointer wraps with no error. A ninth call without a return overwrites the oldest row, and a return past the bottom moves to the top row.
- R8: A refresh happens only in a cycle whose command is 0 (no operation). `rfsh_done_o` pulses one cycle after such a cycle and then names that row in `rfsh_row_o`.
- R9: The refresh counter runs through the codes 000, 001, 010, 101, 011, 111, 110, 100 in that order and then repeats. The first row refreshed after reset is 000.
- R10: Refresh keeps the contents. The value written back always equals the row's current content, even when a stack write lands on the held row.
- R11: When at least one cycle in every two is idle, every row is rewritten (by refresh or by a stack write) within `REFRESH_CYCLES` clocks. With nothing but idle cycles, all eight rows are refreshed in 16 clocks.
- R12: The reserved command codes 6 and 7 change neither the stack nor `bus_o`, and they do not count as idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Command: 0 none, 1 call, 2 return, 3 increment, 4 load half, 5 read half, 6/7 reserved |
| tgt_i | input | 14 | Target address written by a call |
| half_sel_i | input | 1 | 0 selects the low byte, 1 selects the high six bits |
| bus_i | input | 8 | Data for load half |
| bus_o | output | 8 | Registered half of the selected row |
| pc_o | output | 14 | Selected row, which is the program counter |
| rfsh_done_o | output | 1 | Pulses after a row has been written back by refresh |
| rfsh_row_o | output | 3 | Code of the row just refreshed |

## Verification
The bench goes after pointer wrap in both directions. A pointer that saturated, or that stepped in binary order on one side only, would return the wrong address after a ninth call or after unwinding past the bottom. It drives increments across 3FFF and loads the high half with a full byte, so a design that carried into a missing bit or stored bits 7:6 of the bus would show a wrong program counter. Long mixed call, return, increment and half-access traffic runs while refresh sits in HOLD. A design that wrote back its stale copy after a stack write to the held row would silently revert an address, and a scoreboard reference model catches that on the next return. Idle windows check the refresh order, the sweep time, and that no refresh report follows a busy cycle.

// File: rtl/ras_pkg.sv
package ras_pkg;

    localparam int PTR_W = 3;
    localparam int DEPTH = 1 << PTR_W;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_CALL = 3'd1,
        CMD_RET  = 3'd2,
        CMD_INC  = 3'd3,
        CMD_LDH  = 3'd4,
        CMD_RDH  = 3'd5,
        CMD_RSV6 = 3'd6,
        CMD_RSV7 = 3'd7
    } ras_cmd_e;

    typedef enum logic {
        RF_SCAN = 1'b0,
        RF_HOLD = 1'b1
    } rf_state_e;

    // bit shifted in at the right when stepping forward around the cycle
    function automatic logic db_fwd_bit(input logic [PTR_W-1:0] c);
        logic b;
        unique case (c)
            3'b000:  b = 1'b1;
            3'b001:  b = 1'b0;
            3'b010:  b = 1'b1;
            3'b101:  b = 1'b1;
            3'b011:  b = 1'b1;
            3'b111:  b = 1'b0;
            3'b110:  b = 1'b0;
            default: b = 1'b0;
        endcase
        return b;
    endfunction

    // bit shifted in at the left when stepping backward
    function automatic logic db_back_bit(input logic [PTR_W-1:0] c);
        logic b;
        unique case (c)
            3'b000:  b = 1'b1;
            3'b001:  b = 1'b0;
            3'b010:  b = 1'b0;
            3'b101:  b = 1'b0;
            3'b011:  b = 1'b1;
            3'b111:  b = 1'b0;
            3'b110:  b = 1'b1;
            default: b = 1'b1;
        endcase
        return b;
    endfunction

    function automatic logic [PTR_W-1:0] db_next(input logic [PTR_W-1:0] c);
        return {c[PTR_W-2:0], db_fwd_bit(c)};
    endfunction

    function automatic logic [PTR_W-1:0] db_prev(input logic [PTR_W-1:0] c);
        return {db_back_bit(c), c[PTR_W-1:1]};
    endfunction

endpackage

// File: rtl/ras_dbc.sv
module ras_dbc
    import ras_pkg::*;
#(
    parameter bit BIDIR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [PTR_W-1:0] code_o
);

    logic [PTR_W-1:0] code_q;
    logic [PTR_W-1:0] code_d;

    generate
        if (BIDIR) begin : g_bidir
            always_comb begin
                code_d = code_q;
                if (step_up) begin
                    code_d = db_next(code_q);
                end else if (step_dn) begin
                    code_d = db_prev(code_q);
                end
            end
        end else begin : g_fwd_only
            logic unused_dn;
            assign unused_dn = step_dn;
            always_comb begin
                code_d = code_q;
                if (step_up) begin
                    code_d = db_next(code_q);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign code_o = code_q;

    // R2
    fwd_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |=> code_q[PTR_W-1:1] == $past(code_q[PTR_W-2:0]));

    // R3
    back_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (BIDIR && step_dn && !step_up) |=> code_q[PTR_W-2:0] == $past(code_q[PTR_W-1:1]));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_up && !(BIDIR && step_dn)) |=> $stable(code_q));

endmodule

// File: rtl/ras_rows.sv
module ras_rows #(
    parameter int W      = 14,
    parameter int ROWS   = 8,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stk_we,
    input  logic [IDX_W-1:0] stk_idx,
    input  logic [W-1:0]     stk_wd,
    input  logic             rf_we,
    input  logic [IDX_W-1:0] rf_idx,
    input  logic [W-1:0]     rf_wd,
    input  logic [IDX_W-1:0] top_idx,
    output logic [W-1:0]     top_data,
    input  logic [IDX_W-1:0] scan_idx,
    output logic [W-1:0]     scan_data
);

    logic [W-1:0] row_w [ROWS];

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            logic [W-1:0] cell_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q <= '0;
                end else if (stk_we && stk_idx == IDX_W'(r)) begin
                    cell_q <= stk_wd;
                end else if (rf_we && rf_idx == IDX_W'(r)) begin
                    cell_q <= rf_wd;
                end
            end
            assign row_w[r] = cell_q;
        end
    endgenerate

    assign top_data  = row_w[top_idx];
    assign scan_data = row_w[scan_idx];

    // R8
    single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_we && rf_we));

endmodule

// File: rtl/ras_refresh.sv
module ras_refresh
    import ras_pkg::*;
#(
    parameter int W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_i,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_row_i,
    input  logic [W-1:0]     row_data_i,
    output logic [PTR_W-1:0] row_o,
    output logic             we_o,
    output logic [W-1:0]     wd_o,
    output logic             done_o,
    output logic [PTR_W-1:0] done_row_o
);

    rf_state_e        st_q;
    rf_state_e        st_d;
    logic             capture;
    logic             restore;
    logic             advance;
    logic [W-1:0]     copy_q;
    logic [PTR_W-1:0] row;
    logic             done_q;
    logic [PTR_W-1:0] done_row_q;

    ras_dbc #(.BIDIR(1'b0)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_up (advance),
        .step_dn (1'b0),
        .code_o  (row)
    );

    // next-state logic
    always_comb begin
        st_d    = st_q;
        capture = 1'b0;
        restore = 1'b0;
        advance = 1'b0;
        unique case (st_q)
            RF_SCAN: begin
                if (idle_i) begin
                    capture = 1'b1;
                    st_d    = RF_HOLD;
                end
            end
            RF_HOLD: begin
                if (idle_i) begin
                    restore = 1'b1;
                    advance = 1'b1;
                    st_d    = RF_SCAN;
                end else if (wr_en_i && wr_row_i == row) begin
                    advance = 1'b1;
                    st_d    = RF_SCAN;
                end
            end
            default: st_d = RF_SCAN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RF_SCAN;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs and held copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            copy_q     <= '0;
            done_q     <= 1'b0;
            done_row_q <= '0;
        end else begin
            if (capture) begin
                copy_q <= row_data_i;
            end
            done_q <= restore;
            if (restore) begin
                done_row_q <= row;
            end
        end
    end

    assign row_o      = row;
    assign we_o       = restore;
    assign wd_o       = copy_q;
    assign done_o     = done_q;
    assign done_row_o = done_row_q;

    // R10
    writeback_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> wd_o == row_data_i);

    // R9
    done_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> row == db_next(done_row_o));

endmodule

// File: rtl/ras_top.sv
module ras_top
    import ras_pkg::*;
#(
    parameter int ADDR_W         = 14,
    parameter int BUS_W          = 8,
    parameter int REFRESH_CYCLES = 12000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [ADDR_W-1:0] tgt_i,
    input  logic              half_sel_i,
    input  logic [BUS_W-1:0]  bus_i,
    output logic [BUS_W-1:0]  bus_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              rfsh_done_o,
    output logic [PTR_W-1:0]  rfsh_row_o
);

    localparam int HI_W  = ADDR_W - BUS_W;
    localparam int AGE_W = $clog2(REFRESH_CYCLES + 2);

    ras_cmd_e          cmd;
    logic [PTR_W-1:0]  ptr;
    logic              ptr_up;
    logic              ptr_dn;
    logic              idle;
    logic              rd_half;
    logic              stk_we;
    logic [PTR_W-1:0]  stk_idx;
    logic [ADDR_W-1:0] stk_wd;
    logic [ADDR_W-1:0] top_data;
    logic [ADDR_W-1:0] scan_data;
    logic [PTR_W-1:0]  rf_idx;
    logic              rf_we;
    logic [ADDR_W-1:0] rf_wd;
    logic [BUS_W-1:0]  bus_q;

    assign cmd = ras_cmd_e'(cmd_i);

    ras_dbc #(.BIDIR(1'b1)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_up (ptr_up),
        .step_dn (ptr_dn),
        .code_o  (ptr)
    );

    // command decode
    always_comb begin
        ptr_up  = 1'b0;
        ptr_dn  = 1'b0;
        idle    = 1'b0;
        rd_half = 1'b0;
        stk_we  = 1'b0;
        stk_idx = ptr;
        stk_wd  = top_data;
        unique case (cmd)
            CMD_NOP: idle = 1'b1;
            CMD_CALL: begin
                ptr_up  = 1'b1;
                stk_we  = 1'b1;
                stk_idx = db_next(ptr);
                stk_wd  = tgt_i;
            end
            CMD_RET: ptr_dn = 1'b1;
            CMD_INC: begin
                stk_we = 1'b1;
                stk_wd = top_data + 1'b1;
            end
            CMD_LDH: begin
                stk_we = 1'b1;
                if (half_sel_i) begin
                    stk_wd = {bus_i[HI_W-1:0], top_data[BUS_W-1:0]};
                end else begin
                    stk_wd = {top_data[ADDR_W-1:BUS_W], bus_i};
                end
            end
            CMD_RDH: rd_half = 1'b1;
            default: ;
        endcase
    end

    ras_rows #(.W(ADDR_W), .ROWS(DEPTH)) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .stk_we    (stk_we),
        .stk_idx   (stk_idx),
        .stk_wd    (stk_wd),
        .rf_we     (rf_we),
        .rf_idx    (rf_idx),
        .rf_wd     (rf_wd),
        .top_idx   (ptr),
        .top_data  (top_data),
        .scan_idx  (rf_idx),
        .scan_data (scan_data)
    );

    ras_refresh #(.W(ADDR_W)) u_rfsh (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_i     (idle),
        .wr_en_i    (stk_we),
        .wr_row_i   (stk_idx),
        .row_data_i (scan_data),
        .row_o      (rf_idx),
        .we_o       (rf_we),
        .wd_o       (rf_wd),
        .done_o     (rfsh_done_o),
        .done_row_o (rfsh_row_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else if (rd_half) begin
            if (half_sel_i) begin
                bus_q <= BUS_W'(top_data[ADDR_W-1:BUS_W]);
            end else begin
                bus_q <= top_data[BUS_W-1:0];
            end
        end
    end

    assign bus_o = bus_q;
    assign pc_o  = top_data;

    // R8
    rfsh_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_done_o |-> $past(cmd_i) == 3'd0);

    // R4
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == 3'd3 |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

    // R5
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i != 3'd5 |=> $stable(bus_o));

    generate
        for (genvar r = 0; r < DEPTH; r++) begin : g_age
            logic [AGE_W-1:0] age_q;
            logic             renew;
            assign renew = (stk_we && stk_idx == PTR_W'(r)) || (rf_we && rf_idx == PTR_W'(r));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    age_q <= '0;
                end else if (renew) begin
                    age_q <= '0;
                end else if (age_q != '1) begin
                    age_q <= age_q + 1'b1;
                end
            end
            // R11
            row_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
                age_q <= AGE_W'(REFRESH_CYCLES));
        end
    endgenerate

endmodule

// File: tb/ras_top_tb.sv
module ras_top_tb;

    localparam int AW = 14;
    localparam int BW = 8;
    localparam int RC = 80;

    localparam logic [2:0] C_NOP  = 3'd0;
    localparam logic [2:0] C_CALL = 3'd1;
    localparam logic [2:0] C_RET  = 3'd2;
    localparam logic [2:0] C_INC  = 3'd3;
    localparam logic [2:0] C_LDH  = 3'd4;
    localparam logic [2:0] C_RDH  = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd = C_NOP;
    logic [AW-1:0] tgt = '0;
    logic          half = 1'b0;
    logic [BW-1:0] bin = '0;
    logic [BW-1:0] bus_o;
    logic [AW-1:0] pc_o;
    logic          rfsh_done_o;
    logic [2:0]    rfsh_row_o;

    always #10 clk = ~clk;

    ras_top #(.ADDR_W(AW), .BUS_W(BW), .REFRESH_CYCLES(RC)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .tgt_i       (tgt),
        .half_sel_i  (half),
        .bus_i       (bin),
        .bus_o       (bus_o),
        .pc_o        (pc_o),
        .rfsh_done_o (rfsh_done_o),
        .rfsh_row_o  (rfsh_row_o)
    );

    typedef struct {
        logic [AW-1:0] pc;
        logic [BW-1:0] bus;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            n_cmp = 0;
    int            n_bad = 0;
    logic [AW-1:0] mdl [8];
    int            sp = 0;
    logic [BW-1:0] bus_exp = '0;
    logic [2:0]    seq [8] = '{3'b000, 3'b001, 3'b010, 3'b101, 3'b011, 3'b111, 3'b110, 3'b100};

    logic          ph_on = 1'b0;
    logic          have_prev = 1'b0;
    logic [2:0]    prev_row = '0;
    int            ph_dones = 0;
    logic [2:0]    cmd_at_edge;

    function automatic logic [2:0] nxt_row(input logic [2:0] r);
        logic [2:0] n = '0;
        for (int i = 0; i < 8; i++) begin
            if (seq[i] == r) n = seq[(i + 1) % 8];
        end
        return n;
    endfunction

    task automatic chk(input logic ok, input string tag, input string act, input string expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // scoreboard monitor and refresh monitor
    always @(posedge clk) begin
        exp_t e;
        cmd_at_edge = cmd;
        #2;
        if (rst_n && sb.size() > 0) begin
            e = sb.pop_front();
            chk(pc_o === e.pc && bus_o === e.bus, e.tag,
                $sformatf("pc=%h bus=%h", pc_o, bus_o),
                $sformatf("pc=%h bus=%h", e.pc, e.bus));
        end
        if (rst_n && rfsh_done_o) begin
            // R8 refresh only after an idle command
            chk(cmd_at_edge == C_NOP, "R8", $sformatf("cmd=%0d", cmd_at_edge), "cmd=0");
            if (ph_on) begin
                ph_dones++;
                if (have_prev) begin
                    // R9 refresh order
                    chk(rfsh_row_o == nxt_row(prev_row), "R9",
                        $sformatf("row=%b", rfsh_row_o), $sformatf("row=%b", nxt_row(prev_row)));
                end
                have_prev = 1'b1;
                prev_row  = rfsh_row_o;
            end
        end
    end

    task automatic issue(input logic [2:0] c, input logic [AW-1:0] t, input logic h,
                         input logic [BW-1:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        case (c)
            C_CALL: begin sp = (sp + 1) % 8; mdl[sp] = t; end
            C_RET:  sp = (sp + 7) % 8;
            C_INC:  mdl[sp] = mdl[sp] + 1'b1;
            C_LDH:  if (h) mdl[sp][AW-1:BW] = b[AW-BW-1:0]; else mdl[sp][BW-1:0] = b;
            C_RDH:  bus_exp = h ? BW'(mdl[sp][AW-1:BW]) : mdl[sp][BW-1:0];
            default: ;
        endcase
        e.pc  = mdl[sp];
        e.bus = bus_exp;
        e.tag = tag;
        sb.push_back(e);
        cmd  = c;
        tgt  = t;
        half = h;
        bin  = b;
        @(negedge clk);
        cmd = C_NOP;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pc_o == '0 && bus_o == '0 && rfsh_done_o == 1'b0, "R1",
            $sformatf("pc=%h bus=%h done=%b", pc_o, bus_o, rfsh_done_o), "pc=0 bus=0 done=0");
        ph_on     = 1'b1;
        have_prev = 1'b1;
        prev_row  = 3'b100;
        rst_n     = 1'b1;
        idle(16);
        ph_on = 1'b0;
        // R11 full sweep in 16 idle clocks
        chk(ph_dones == 8, "R11", $sformatf("dones=%0d", ph_dones), "dones=8");

        // R2 calls
        issue(C_CALL, 14'h0123, 1'b0, 8'h00, "R2");
        issue(C_CALL, 14'h3FFF, 1'b0, 8'h00, "R2");
        issue(C_CALL, 14'h0000, 1'b0, 8'h00, "R2");
        issue(C_CALL, 14'h2A5C, 1'b0, 8'h00, "R2");
        // R5 half reads
        issue(C_RDH, '0, 1'b0, 8'h00, "R5");
        issue(C_RDH, '0, 1'b1, 8'h00, "R5");
        issue(C_NOP, '0, 1'b0, 8'h00, "R5");
        // R6 half loads, high half takes only six bits
        issue(C_LDH, '0, 1'b0, 8'hA5, "R6");
        issue(C_LDH, '0, 1'b1, 8'hFF, "R6");
        issue(C_RDH, '0, 1'b1, 8'h00, "R6");
        issue(C_LDH, '0, 1'b1, 8'h40, "R6");
        // R4 increment with wrap
        issue(C_CALL, 14'h3FFF, 1'b0, 8'h00, "R2");
        issue(C_INC, '0, 1'b0, 8'h00, "R4");
        issue(C_INC, '0, 1'b0, 8'h00, "R4");
        // R3 returns
        for (int i = 0; i < 5; i++) issue(C_RET, '0, 1'b0, 8'h00, "R3");
        // R7 wrap both ways
        for (int i = 0; i < 10; i++) issue(C_CALL, AW'(14'h100 + i * 7), 1'b0, 8'h00, "R7");
        for (int i = 0; i < 12; i++) issue(C_RET, '0, 1'b0, 8'h00, "R7");
        // R12 reserved codes
        issue(3'd6, 14'h1555, 1'b1, 8'h33, "R12");
        issue(3'd7, 14'h2AAA, 1'b0, 8'hCC, "R12");
        issue(C_RDH, '0, 1'b0, 8'h00, "R12");
        issue(3'd7, 14'h0F0F, 1'b1, 8'h11, "R12");

        // R10 contents survive many refresh sweeps
        ph_on     = 1'b1;
        have_prev = 1'b0;
        idle(100);
        ph_on = 1'b0;
        for (int i = 0; i < 9; i++) issue(C_RET, '0, 1'b0, 8'h00, "R10");

        // mixed traffic against the reference model
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[2:0])
                3'd0, 3'd1, 3'd2: issue(C_CALL, lf[15:2] ^ AW'(i), 1'b0, 8'h00, "R2");
                3'd3, 3'd4:       issue(C_RET, '0, 1'b0, 8'h00, "R3");
                3'd5:             issue(C_INC, '0, 1'b0, 8'h00, "R4");
                3'd6:             issue(C_LDH, '0, lf[9], lf[15:8], "R6");
                default:          issue(C_RDH, '0, lf[11], 8'h00, "R5");
            endcase
        end
        ph_on     = 1'b1;
        have_prev = 1'b0;
        idle(40);
        ph_on = 1'b0;
        for (int i = 0; i < 8; i++) issue(C_RET, '0, 1'b0, 8'h00, "R10");
        idle(4);
        summary();
        $finish;
    end

endmodule